// File: doc/BRIEF.md
# Selectable Serial Line-Code Encoder

This block turns a stream of single data bits into one coded output line. A free-running strobe, `half_tick`, arrives at twice the bit rate, so two strobes make one bit slot. The first strobe of each pair is a bit boundary. At a boundary the encoder offers `bit_ready`. A bit is taken when `bit_valid` is high in that same cycle. The strobe that follows is the mid-bit point, where the line moves to its second-half level.

Four line codes can be chosen with `mode_sel`: plain NRZ, unipolar return-to-zero, NRZI (inverted on zero) and Manchester. The encoder keeps the NRZI running level from one bit to the next. It reads the mode select only at a boundary, so every bit is sent whole in a single code. Decoding, clock recovery, bit stuffing and bipolar levels are not part of this block.

Top module: `line_code_enc`

## Requirements
- R1: After reset, `line_out` is 0, the running level is high and the mode is NRZ. The first `half_tick` after reset is a bit boundary.
- R2: `bit_ready` is high only in a cycle with `half_tick` high, and only on every second strobe, starting with the first. A bit is accepted when `bit_valid` and `bit_ready` are both high.
- R3: Mode 0 (NRZ): for an accepted bit, the line equals the bit for both halves of the slot.
- R4: Mode 1 (RZ): an accepted 1 drives the line high for the first half of the slot and low for the second half. An accepted 0 keeps the line low for the whole slot.
- R5: Mode 2 (NRZI): an accepted 0 inverts the running level and an accepted 1 keeps it. The line follows the running level for the whole slot, so a run of ones leaves the line constant.
- R6: Mode 3 (Manchester): an accepted 1 is low in the first half and high in the second. An accepted 0 is high and then low. Every bit therefore has a mid-bit transition.
- R7: `mode_sel` is sampled only at a bit boundary. A change between a boundary and the following mid-bit strobe does not alter the second half of the slot.
- R8: When the mode sampled at a boundary differs from the previous one, the NRZI running level returns to high before the bit is applied.
- R9: A slot with no accepted bit drives the line low in modes 0 and 1. It drives the running level in mode 2, and holds the previous line level in mode 3.
- R10: `line_out` changes only on a clock edge at which `half_tick` is high. The new level is visible after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| half_tick | input | 1 | One-cycle strobe at twice the bit rate |
| mode_sel | input | 2 | Line code: 0 NRZ, 1 RZ, 2 NRZI, 3 Manchester |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Data bit value |
| bit_ready | output | 1 | Boundary strobe: the offered bit is taken in this cycle |
| line_out | output | 1 | Coded output line |

## Verification
The assertions assume that `half_tick` is a single-cycle pulse with idle cycles between pulses. They also assume that `bit_valid`, `bit_data` and `mode_sel` are settled whenever a boundary strobe occurs. The bench drives every input on the falling clock edge and keeps at least three idle cycles between strobes. It always produces strobes in boundary and mid-bit pairs. It changes `mode_sel` inside a slot on purpose to probe mode sampling, but always restores the wanted mode before the next boundary.

// File: rtl/lc_pkg.sv
package lc_pkg;
  typedef enum logic [1:0] {
    LC_NRZ  = 2'd0,
    LC_RZ   = 2'd1,
    LC_NRZI = 2'd2,
    LC_MAN  = 2'd3
  } lc_mode_e;
endpackage

// File: rtl/lc_phase.sv
module lc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic half_tick,
  output logic at_bound,
  output logic at_mid
);
  logic phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (half_tick) phase_d = ~phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= 1'b1;
    else        phase_q <= phase_d;
  end

  assign at_bound = half_tick & phase_q;
  assign at_mid   = half_tick & ~phase_q;

  assert_bound_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_bound |=> !at_bound);
  assert_mid_alternates_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_mid |=> !at_mid);
endmodule

// File: rtl/lc_nrzi_state.sv
module lc_nrzi_state
  import lc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take,
  input  lc_mode_e mode_new,
  input  logic     mode_chg,
  input  logic     valid,
  input  logic     data,
  output logic     lvl_q,
  output logic     lvl_nx
);
  logic base, lvl_d;

  always_comb begin
    base = mode_chg ? 1'b1 : lvl_q;
    if (mode_new != LC_NRZI)  lvl_nx = 1'b1;
    else if (valid && !data)  lvl_nx = ~base;
    else                      lvl_nx = base;
    lvl_d = take ? lvl_nx : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= 1'b1;
    else        lvl_q <= lvl_d;
  end

  assert_ones_keep_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && valid && data && !mode_chg && mode_new == LC_NRZI) |=> $stable(lvl_q));
  assert_zero_flips_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && valid && !data && !mode_chg && mode_new == LC_NRZI) |=> lvl_q != $past(lvl_q));
  assert_change_resets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode_chg && !(valid && !data)) |=> lvl_q);
endmodule

// File: rtl/lc_level_map.sv
module lc_level_map
  import lc_pkg::*;
(
  input  lc_mode_e mode,
  input  logic     valid,
  input  logic     data,
  input  logic     lvl,
  input  logic     prev,
  input  logic     second,
  output logic     y
);
  always_comb begin
    unique case (mode)
      LC_NRZ:  y = valid & data;
      LC_RZ:   y = valid & data & ~second;
      LC_NRZI: y = lvl;
      LC_MAN:  y = valid ? (second ? data : ~data) : prev;
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/line_code_enc.sv
module line_code_enc
  import lc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic [1:0] mode_sel,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic       line_out
);
  logic     at_bound, at_mid;
  lc_mode_e mode_in, mode_q, mode_d;
  logic     bit_q, bit_d, act_q, act_d, line_q, line_d;
  logic     mode_chg, lvl_q, lvl_nx;
  logic     y_first, y_second;

  assign mode_in  = lc_mode_e'(mode_sel);
  assign mode_chg = (mode_in != mode_q);

  lc_phase u_phase (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick),
    .at_bound(at_bound), .at_mid(at_mid)
  );

  lc_nrzi_state u_nrzi (
    .clk(clk), .rst_n(rst_n), .take(at_bound), .mode_new(mode_in),
    .mode_chg(mode_chg), .valid(bit_valid), .data(bit_data),
    .lvl_q(lvl_q), .lvl_nx(lvl_nx)
  );

  lc_level_map u_map_first (
    .mode(mode_in), .valid(bit_valid), .data(bit_data), .lvl(lvl_nx),
    .prev(line_q), .second(1'b0), .y(y_first)
  );

  lc_level_map u_map_second (
    .mode(mode_q), .valid(act_q), .data(bit_q), .lvl(lvl_q),
    .prev(line_q), .second(1'b1), .y(y_second)
  );

  always_comb begin
    mode_d = mode_q;
    bit_d  = bit_q;
    act_d  = act_q;
    line_d = line_q;
    if (at_bound) begin
      mode_d = mode_in;
      bit_d  = bit_data;
      act_d  = bit_valid;
      line_d = y_first;
    end else if (at_mid) begin
      line_d = y_second;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= LC_NRZ;
      bit_q  <= 1'b0;
      act_q  <= 1'b0;
      line_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      bit_q  <= bit_d;
      act_q  <= act_d;
      line_q <= line_d;
    end
  end

  assign bit_ready = at_bound;
  assign line_out  = line_q;

  assert_ready_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> half_tick);
  assert_hold_between_ticks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !half_tick |=> $stable(line_out));
  assert_nrz_flat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && mode_q == LC_NRZ) |=> $stable(line_out));
  assert_rz_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && mode_q == LC_RZ) |=> !line_out);
  assert_man_mid_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (at_mid && act_q && mode_q == LC_MAN) |=> line_out != $past(line_out));
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (at_bound && !bit_valid && (mode_in == LC_NRZ || mode_in == LC_RZ)) |=> !line_out);
endmodule

// File: tb/line_code_enc_tb.sv
module line_code_enc_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 3;

  logic clk = 1'b0, rst_n = 1'b0, half_tick = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic bit_valid = 1'b0, bit_data = 1'b0;
  logic bit_ready, line_out;

  int n_tests = 0, n_fail = 0;
  logic [1:0] mode_m = 2'd0;
  logic lvl_m = 1'b1, line_m = 1'b0;
  logic pend_v = 1'b0, pend_d = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_code_enc dut_i (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .mode_sel(mode_sel),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .line_out(line_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m, input logic v);
    if (!v) return "R9";
    case (m)
      2'd0: return "R3";
      2'd1: return "R4";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic exp_level(input logic [1:0] m, input logic v, input logic d,
                                     input logic second);
    case (m)
      2'd0: return v & d;
      2'd1: return v & d & ~second;
      2'd2: return lvl_m;
      default: return v ? (second ? d : ~d) : line_m;
    endcase
  endfunction

  task automatic model_bound(input logic [1:0] m, input logic v, input logic d);
    if (m != mode_m) lvl_m = 1'b1;
    mode_m = m;
    if (m != 2'd2) lvl_m = 1'b1;
    else if (v && !d) lvl_m = ~lvl_m;
    pend_v = v;
    pend_d = d;
    line_m = exp_level(m, v, d, 1'b0);
  endtask

  task automatic model_mid();
    line_m = exp_level(mode_m, pend_v, pend_d, 1'b1);
  endtask

  task automatic slot(input logic [1:0] m, input logic v, input logic d, input logic glitch);
    logic held;
    mode_sel = m; bit_valid = v; bit_data = d;
    @(negedge clk) half_tick = 1'b1;
    #1 chk("R2 ready at boundary", bit_ready, 1'b1);
    @(negedge clk) half_tick = 1'b0; bit_valid = 1'b0; bit_data = ~d;
    if (glitch) mode_sel = m + 2'd1;
    model_bound(m, v, d);
    #1 chk(mode_tag(m, v), line_out, line_m);
    held = line_out;
    repeat (GAP) @(negedge clk);
    #1 chk("R10 stable between ticks", line_out, held);
    chk("R2 no ready between ticks", bit_ready, 1'b0);
    @(negedge clk) half_tick = 1'b1;
    #1 chk("R2 no ready at mid", bit_ready, 1'b0);
    @(negedge clk) half_tick = 1'b0;
    model_mid();
    #1 chk(glitch ? "R7" : mode_tag(m, v), line_out, line_m);
    repeat (GAP) @(negedge clk);
    mode_sel = m;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [1:0] m;
    logic flat;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    #1 chk("R1 line low in reset", line_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk("R1 line low after reset", line_out, 1'b0);
    chk("R1 no ready without tick", bit_ready, 1'b0);

    // first tick is a boundary; NRZ idle then data
    slot(2'd0, 1'b0, 1'b1, 1'b0);
    slot(2'd0, 1'b1, 1'b1, 1'b0);
    slot(2'd0, 1'b1, 1'b0, 1'b0);
    // RZ ones and zero
    slot(2'd1, 1'b1, 1'b1, 1'b0);
    slot(2'd1, 1'b1, 1'b0, 1'b0);
    // NRZI run of ones: line constant
    slot(2'd2, 1'b1, 1'b1, 1'b0);
    flat = line_out;
    for (int i = 0; i < 6; i++) slot(2'd2, 1'b1, 1'b1, 1'b0);
    chk("R5 ones keep level", line_out, flat);
    // NRZI zero drives low, mode change then back resets high (R8)
    slot(2'd2, 1'b1, 1'b0, 1'b0);
    chk("R5 zero toggles", line_out, 1'b0);
    slot(2'd1, 1'b0, 1'b0, 1'b0);
    slot(2'd2, 1'b1, 1'b1, 1'b0);
    chk("R8 level reset on mode change", line_out, 1'b1);
    // Manchester with idle hold
    slot(2'd3, 1'b1, 1'b1, 1'b0);
    slot(2'd3, 1'b0, 1'b0, 1'b0);
    chk("R9 manchester idle holds", line_out, 1'b1);
    slot(2'd3, 1'b1, 1'b0, 1'b1);
    slot(2'd1, 1'b1, 1'b1, 1'b1);

    m = 2'd0;
    for (int i = 0; i < 400; i++) begin
      if ($urandom % 8 == 0) m = 2'($urandom % 4);
      slot(m, ($urandom % 4) != 0, 1'($urandom % 2), ($urandom % 4) == 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule